// File: doc/BRIEF.md
# BCD Calendar Clock Counter

The block keeps wall-clock time and a calendar in packed BCD registers. It counts seconds, minutes, hours, day of week, day of month, month and a two-digit year, with a century bit kept in the month register. A one-cycle `tick_i` pulse, expected once per second, advances the count. Carries run from seconds up through years. The day counter wraps at the length of the current month, including a leap February. The hour register has two encodings, 24-hour and 12-hour with a PM bit, and a control bit picks between them.

A bus front end reaches every register through one parallel port. A write lands on the next clock edge. A read is combinational from the address. Two sticky status flags live in a second control register. One reports that the oscillator has stopped, and while it is set the count is frozen. The other reports a low supply and does not stop the count. Writing zero to that register clears both flags.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the time reads 00 seconds and 00 minutes, the hour reads 0x12 (12-hour midnight) and the weekday reads 0. Day of month and month read 0x01, year reads 0x00 and the century bit is clear. The mode register (address 14) reads 0x00, and the status register (address 15) reads 0x10, which means the oscillator-stopped flag is set.
- R2: Register addresses are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month, 6 year, 14 mode and 15 status. A write stores only these bits: 6:0 of seconds and minutes, 5:0 of hours and day, 2:0 of weekday, bit 7 plus 4:0 of month, all of year, bit 5 of mode, and bits 6 and 4 of status. Seconds bit 7 always reads 0. Any other address reads 0x00 and writes to it change nothing.
- R3: While status bit 4 is set, a tick changes no time register. Writing 0x00 to status clears bit 4 and bit 6, and ticks then count.
- R4: An `osc_fault_i` pulse sets status bit 4. A `supply_low_i` pulse sets status bit 6, and the count keeps running.
- R5: A tick steps seconds in BCD. 0x59 goes to 0x00 and steps minutes, and minutes 0x59 goes to 0x00 and steps the hour.
- R6: With mode bit 5 set, hours run 0x00 to 0x23. A step from 0x23 goes to 0x00 and advances the day.
- R7: With mode bit 5 clear, bits 4:0 of the hour run 12, 01 … 11 in BCD and bit 5 is PM. 0x11 steps to 0x32 (noon). 0x31 steps to 0x12 (midnight) and advances the day. 0x12 and 0x32 step to 0x01 and 0x21.
- R8: The day wraps to 0x01 after 31 in months 1, 3, 5, 7, 8, 10 and 12, and after 30 in months 4, 6, 9 and 11. In February it wraps after 29 when the BCD year is divisible by 4, and after 28 otherwise.
- R9: The weekday steps 0 to 6 and wraps to 0, once at each day rollover.
- R10: Month 0x12 wraps to 0x01 and steps the year. Year 0x99 wraps to 0x00 and toggles month bit 7, the century bit.
- R11: In a cycle that has both a write and a tick, the write lands and the tick is dropped for every register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle advance pulse, once per second |
| osc_fault_i | input | 1 | Pulse that sets the oscillator-stopped flag |
| supply_low_i | input | 1 | Pulse that sets the low-supply flag |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address for read and write |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i`, combinational |

## Verification
State in this block is visible at the port only after a carry reaches it. A wrong month-length table shows up only at the one tick that leaves the last day of the affected month. A wrong 12-hour encoding shows up only at the 11→12 and 12→01 steps. The bench therefore loads each boundary state directly, one tick before its carry, and reads every time register after that single tick, so a fault is caught within one tick of where it acts. The status and masking behaviour can be seen at once on the read port.

// File: rtl/cal_pkg.sv
package cal_pkg;
   localparam logic [3:0] RA_SEC  = 4'd0;
   localparam logic [3:0] RA_MIN  = 4'd1;
   localparam logic [3:0] RA_HOUR = 4'd2;
   localparam logic [3:0] RA_WDAY = 4'd3;
   localparam logic [3:0] RA_MDAY = 4'd4;
   localparam logic [3:0] RA_MON  = 4'd5;
   localparam logic [3:0] RA_YEAR = 4'd6;
   localparam logic [3:0] RA_MODE = 4'd14;
   localparam logic [3:0] RA_STAT = 4'd15;

   // stepper lane indices
   localparam int LN_SEC  = 0;
   localparam int LN_MIN  = 1;
   localparam int LN_WDAY = 2;
   localparam int LN_MDAY = 3;
   localparam int LN_MON  = 4;
   localparam int LN_YEAR = 5;
   localparam int N_LANES = 6;

   localparam int BIT_H24   = 5;
   localparam int BIT_OSTOP = 4;
   localparam int BIT_VLOW  = 6;
endpackage

// File: rtl/cal_bcd_step.sv
module cal_bcd_step #(
   parameter int W = 8
) (
   input  logic [W-1:0] cur_i,
   input  logic [W-1:0] first_i,
   input  logic [W-1:0] last_i,
   output logic [W-1:0] next_o,
   output logic         wrap_o
);
   if (W < 5) begin : g_bad_w
      $error("cal_bcd_step needs at least two BCD nibbles");
   end

   always_comb begin
      wrap_o = (cur_i == last_i);
      if (wrap_o)
         next_o = first_i;
      else if (cur_i[3:0] >= 4'h9)
         next_o = {cur_i[W-1:4] + (W-4)'(1), 4'h0};
      else
         next_o = cur_i + W'(1);
   end
endmodule

// File: rtl/cal_hour_step.sv
module cal_hour_step (
   input  logic [5:0] hour_i,
   input  logic       mode24_i,
   output logic [5:0] next_o,
   output logic       carry_o
);
   logic       pm;
   logic [4:0] dig;

   assign pm  = hour_i[5];
   assign dig = hour_i[4:0];

   always_comb begin
      carry_o = 1'b0;
      if (mode24_i) begin
         if (hour_i == 6'h23) begin
            next_o  = 6'h00;
            carry_o = 1'b1;
         end else if (hour_i[3:0] >= 4'h9) begin
            next_o = {hour_i[5:4] + 2'd1, 4'h0};
         end else begin
            next_o = hour_i + 6'd1;
         end
      end else begin
         if (dig == 5'h12) begin
            next_o = {pm, 5'h01};
         end else if (dig == 5'h11) begin
            next_o  = {~pm, 5'h12};
            carry_o = pm;
         end else if (dig[3:0] >= 4'h9) begin
            next_o = {pm, 1'b1, 4'h0};
         end else begin
            next_o = {pm, dig + 5'd1};
         end
      end
   end
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len (
   input  logic [4:0] month_i,
   input  logic [7:0] year_i,
   output logic [5:0] last_o
);
   logic [5:0] mod_sum;
   logic       leap;

   // 10*t + o is congruent to 2*t + o modulo 4
   assign mod_sum = {1'b0, year_i[7:4], 1'b0} + {2'b00, year_i[3:0]};
   assign leap    = (mod_sum[1:0] == 2'b00);

   always_comb begin
      unique case (month_i)
         5'h02:                      last_o = leap ? 6'h29 : 6'h28;
         5'h04, 5'h06, 5'h09, 5'h11: last_o = 6'h30;
         default:                    last_o = 6'h31;
      endcase
   end
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock #(
   parameter int DATA_W        = 8,
   parameter int ADDR_W        = 4,
   parameter bit RESET_STOPPED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              osc_fault_i,
   input  logic              supply_low_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o
);
   import cal_pkg::*;

   localparam int LW = 8;

   if (ADDR_W != 4 || DATA_W < 8) begin : g_bad_cfg
      $error("bcd_calendar_clock: ADDR_W must be 4 and DATA_W at least 8");
   end

   logic [6:0] sec_q, min_q;
   logic [5:0] hour_q, mday_q;
   logic [2:0] wday_q;
   logic [4:0] mon_q;
   logic       cent_q;
   logic [7:0] year_q;
   logic       h24_q, ostop_q, vlow_q;

   logic [7:0] wb;
   assign wb = wdata_i[7:0];

   // per-lane stepper wiring
   logic [LW-1:0] ln_cur   [N_LANES];
   logic [LW-1:0] ln_first [N_LANES];
   logic [LW-1:0] ln_last  [N_LANES];
   logic [LW-1:0] ln_next  [N_LANES];
   logic [N_LANES-1:0] ln_wrap;

   logic [5:0] mday_last;
   logic [5:0] hour_next;
   logic       hour_carry;

   cal_month_len u_mlen (
      .month_i (mon_q),
      .year_i  (year_q),
      .last_o  (mday_last)
   );

   cal_hour_step u_hour (
      .hour_i   (hour_q),
      .mode24_i (h24_q),
      .next_o   (hour_next),
      .carry_o  (hour_carry)
   );

   always_comb begin
      ln_cur[LN_SEC]    = {1'b0, sec_q};
      ln_first[LN_SEC]  = 8'h00;
      ln_last[LN_SEC]   = 8'h59;
      ln_cur[LN_MIN]    = {1'b0, min_q};
      ln_first[LN_MIN]  = 8'h00;
      ln_last[LN_MIN]   = 8'h59;
      ln_cur[LN_WDAY]   = {5'b0, wday_q};
      ln_first[LN_WDAY] = 8'h00;
      ln_last[LN_WDAY]  = 8'h06;
      ln_cur[LN_MDAY]   = {2'b0, mday_q};
      ln_first[LN_MDAY] = 8'h01;
      ln_last[LN_MDAY]  = {2'b0, mday_last};
      ln_cur[LN_MON]    = {3'b0, mon_q};
      ln_first[LN_MON]  = 8'h01;
      ln_last[LN_MON]   = 8'h12;
      ln_cur[LN_YEAR]   = year_q;
      ln_first[LN_YEAR] = 8'h00;
      ln_last[LN_YEAR]  = 8'h99;
   end

   for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      cal_bcd_step #(.W(LW)) u_step (
         .cur_i   (ln_cur[g]),
         .first_i (ln_first[g]),
         .last_i  (ln_last[g]),
         .next_o  (ln_next[g]),
         .wrap_o  (ln_wrap[g])
      );
   end

   // carry chain
   logic adv, c_min, c_hour, c_day, c_mon, c_year, c_cent;
   assign adv    = tick_i && !ostop_q && !wr_en_i;
   assign c_min  = adv    && ln_wrap[LN_SEC];
   assign c_hour = c_min  && ln_wrap[LN_MIN];
   assign c_day  = c_hour && hour_carry;
   assign c_mon  = c_day  && ln_wrap[LN_MDAY];
   assign c_year = c_mon  && ln_wrap[LN_MON];
   assign c_cent = c_year && ln_wrap[LN_YEAR];

   logic [3:0] ra;
   assign ra = addr_i[3:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q   <= '0;
         min_q   <= '0;
         hour_q  <= 6'h12;
         wday_q  <= '0;
         mday_q  <= 6'h01;
         mon_q   <= 5'h01;
         cent_q  <= 1'b0;
         year_q  <= '0;
         h24_q   <= 1'b0;
         ostop_q <= RESET_STOPPED;
         vlow_q  <= 1'b0;
      end else begin
         if (wr_en_i) begin
            unique case (ra)
               RA_SEC:  sec_q  <= wb[6:0];
               RA_MIN:  min_q  <= wb[6:0];
               RA_HOUR: hour_q <= wb[5:0];
               RA_WDAY: wday_q <= wb[2:0];
               RA_MDAY: mday_q <= wb[5:0];
               RA_MON: begin
                  mon_q  <= wb[4:0];
                  cent_q <= wb[7];
               end
               RA_YEAR: year_q <= wb;
               RA_MODE: h24_q  <= wb[BIT_H24];
               default: ;
            endcase
         end else begin
            if (adv)    sec_q  <= ln_next[LN_SEC][6:0];
            if (c_min)  min_q  <= ln_next[LN_MIN][6:0];
            if (c_hour) hour_q <= hour_next;
            if (c_day) begin
               mday_q <= ln_next[LN_MDAY][5:0];
               wday_q <= ln_next[LN_WDAY][2:0];
            end
            if (c_mon)  mon_q  <= ln_next[LN_MON][4:0];
            if (c_year) year_q <= ln_next[LN_YEAR];
            if (c_cent) cent_q <= ~cent_q;
         end

         // status flags: fault inputs win over a clearing write
         if (wr_en_i && ra == RA_STAT) begin
            ostop_q <= wb[BIT_OSTOP] | osc_fault_i;
            vlow_q  <= wb[BIT_VLOW]  | supply_low_i;
         end else begin
            if (osc_fault_i)  ostop_q <= 1'b1;
            if (supply_low_i) vlow_q  <= 1'b1;
         end
      end
   end

   logic [7:0] rbyte;
   always_comb begin
      unique case (ra)
         RA_SEC:  rbyte = {1'b0, sec_q};
         RA_MIN:  rbyte = {1'b0, min_q};
         RA_HOUR: rbyte = {2'b0, hour_q};
         RA_WDAY: rbyte = {5'b0, wday_q};
         RA_MDAY: rbyte = {2'b0, mday_q};
         RA_MON:  rbyte = {cent_q, 2'b0, mon_q};
         RA_YEAR: rbyte = year_q;
         RA_MODE: rbyte = {2'b0, h24_q, 5'b0};
         RA_STAT: rbyte = {1'b0, vlow_q, 1'b0, ostop_q, 4'b0};
         default: rbyte = 8'h00;
      endcase
   end

   assign rdata_o = DATA_W'(rbyte);
endmodule

// File: rtl/cal_clock_checker.sv
module cal_clock_checker #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_i,
   input logic              osc_fault_i,
   input logic              supply_low_i,
   input logic              wr_en_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic [DATA_W-1:0] wdata_i,
   input logic [DATA_W-1:0] rdata_o,
   input logic [6:0]        sec_q,
   input logic [7:0]        year_q,
   input logic              cent_q,
   input logic              ostop_q,
   input logic              vlow_q
);
   a_r2_sec_top_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_i == ADDR_W'(0)) |-> (rdata_o[7] == 1'b0));

   a_r3_stopped_holds_seconds: assert property (@(posedge clk) disable iff (!rst_n)
      (ostop_q && !wr_en_i) |=> $stable(sec_q));

   a_r3_zero_write_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && addr_i == ADDR_W'(15) && !wdata_i[4] && !wdata_i[6]
       && !osc_fault_i && !supply_low_i) |=> (!ostop_q && !vlow_q));

   a_r4_fault_sets_stop: assert property (@(posedge clk) disable iff (!rst_n)
      osc_fault_i |=> ostop_q);

   a_r5_seconds_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !ostop_q && !wr_en_i && sec_q == 7'h59) |=> (sec_q == 7'h00));

   a_r10_year_wrap_toggles_century: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en_i && year_q == 8'h99) |=> (year_q == 8'h99 || cent_q != $past(cent_q)));

   a_r11_write_drops_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && addr_i != ADDR_W'(0)) |=> $stable(sec_q));
endmodule

bind bcd_calendar_clock cal_clock_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tick_i       (tick_i),
   .osc_fault_i  (osc_fault_i),
   .supply_low_i (supply_low_i),
   .wr_en_i      (wr_en_i),
   .addr_i       (addr_i),
   .wdata_i      (wdata_i),
   .rdata_o      (rdata_o),
   .sec_q        (sec_q),
   .year_q       (year_q),
   .cent_q       (cent_q),
   .ostop_q      (ostop_q),
   .vlow_q       (vlow_q)
);

// File: tb/tb_bcd_calendar_clock.sv
module tb_bcd_calendar_clock;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic       osc_fault_i = 1'b0;
   logic       supply_low_i = 1'b0;
   logic       wr_en_i = 1'b0;
   logic [3:0] addr_i = '0;
   logic [7:0] wdata_i = '0;
   logic [7:0] rdata_o;

   always #2.5 clk = ~clk;

   bcd_calendar_clock dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_i       (tick_i),
      .osc_fault_i  (osc_fault_i),
      .supply_low_i (supply_low_i),
      .wr_en_i      (wr_en_i),
      .addr_i       (addr_i),
      .wdata_i      (wdata_i),
      .rdata_o      (rdata_o)
   );

   int n_cmp = 0;
   int n_bad = 0;

   // bench time model, binary
   int s, m, h, wd, d, mo, y, c, m24;

   function automatic logic [7:0] bcd(int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic int mlen(int mon, int yr);
      if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
      return 31;
   endfunction

   function automatic logic [7:0] hour_code(int hr, int mode);
      int hh;
      if (mode != 0) return bcd(hr);
      hh = (hr % 12 == 0) ? 12 : hr % 12;
      return bcd(hh) | ((hr >= 12) ? 8'h20 : 8'h00);
   endfunction

   task automatic model_step();
      s++;
      if (s == 60) begin
         s = 0; m++;
         if (m == 60) begin
            m = 0; h++;
            if (h == 24) begin
               h = 0; wd = (wd + 1) % 7; d++;
               if (d > mlen(mo, y)) begin
                  d = 1; mo++;
                  if (mo == 13) begin
                     mo = 1; y++;
                     if (y == 100) begin y = 0; c = 1 - c; end
                  end
               end
            end
         end
      end
   endtask

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [3:0] a, logic [7:0] v);
      @(negedge clk);
      wr_en_i = 1'b1; addr_i = a; wdata_i = v;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic rd(logic [3:0] a, output logic [7:0] v);
      @(negedge clk);
      addr_i = a;
      #1 v = rdata_o;
   endtask

   task automatic tick();
      @(negedge clk);
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
   endtask

   task automatic check_all(string tag);
      logic [7:0] v;
      rd(4'd0, v); check({tag, " sec"},   v, bcd(s));
      rd(4'd1, v); check({tag, " min"},   v, bcd(m));
      rd(4'd2, v); check({tag, " hour"},  v, hour_code(h, m24));
      rd(4'd3, v); check({tag, " wday"},  v, bcd(wd));
      rd(4'd4, v); check({tag, " mday"},  v, bcd(d));
      rd(4'd5, v); check({tag, " month"}, v, bcd(mo) | ((c != 0) ? 8'h80 : 8'h00));
      rd(4'd6, v); check({tag, " year"},  v, bcd(y));
   endtask

   task automatic set_mode(int mode);
      m24 = mode;
      wr(4'd14, (mode != 0) ? 8'h20 : 8'h00);
   endtask

   task automatic load(int ns, int nm, int nh, int nwd, int nd, int nmo, int ny, int nc);
      s = ns; m = nm; h = nh; wd = nwd; d = nd; mo = nmo; y = ny; c = nc;
      wr(4'd0, bcd(s));
      wr(4'd1, bcd(m));
      wr(4'd2, hour_code(h, m24));
      wr(4'd3, bcd(wd));
      wr(4'd4, bcd(d));
      wr(4'd5, bcd(mo) | ((c != 0) ? 8'h80 : 8'h00));
      wr(4'd6, bcd(y));
   endtask

   initial begin : watchdog
      #(5 * 150000);
      n_bad++;
      $display("FAIL watchdog: got hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      s = 0; m = 0; h = 0; wd = 0; d = 1; mo = 1; y = 0; c = 0; m24 = 0;

      // R1 reset state
      check_all("R1 reset");
      rd(4'd14, v); check("R1 mode", v, 8'h00);
      rd(4'd15, v); check("R1 status", v, 8'h10);

      // R3 ticks ignored while stopped
      repeat (3) tick();
      check_all("R3 stopped");

      // R2 masks and unused addresses
      wr(4'd0, 8'hFF); rd(4'd0, v); check("R2 sec mask", v, 8'h7F);
      wr(4'd2, 8'hFF); rd(4'd2, v); check("R2 hour mask", v, 8'h3F);
      wr(4'd3, 8'hFF); rd(4'd3, v); check("R2 wday mask", v, 8'h07);
      wr(4'd4, 8'hFF); rd(4'd4, v); check("R2 mday mask", v, 8'h3F);
      wr(4'd5, 8'hFF); rd(4'd5, v); check("R2 month mask", v, 8'h9F);
      wr(4'd14, 8'hFF); rd(4'd14, v); check("R2 mode mask", v, 8'h20);
      wr(4'd15, 8'hFF); rd(4'd15, v); check("R2 status mask", v, 8'h50);
      for (int a = 7; a < 14; a++) begin
         wr(4'(a), 8'hA5); rd(4'(a), v); check("R2 unused", v, 8'h00);
      end

      // R3 clear by zero write, then counting resumes
      wr(4'd15, 8'h00); rd(4'd15, v); check("R3 clear", v, 8'h00);
      set_mode(1);
      load(10, 20, 5, 2, 3, 4, 5, 0);
      tick(); model_step(); check_all("R3 running");

      // R4 low supply flag does not halt
      @(negedge clk); supply_low_i = 1'b1; @(negedge clk); supply_low_i = 1'b0;
      rd(4'd15, v); check("R4 vlow", v, 8'h40);
      tick(); model_step(); check_all("R4 vlow runs");
      // R4 oscillator fault halts
      @(negedge clk); osc_fault_i = 1'b1; @(negedge clk); osc_fault_i = 1'b0;
      rd(4'd15, v); check("R4 ostop", v, 8'h50);
      tick(); check_all("R4 ostop halts");
      wr(4'd15, 8'h00); rd(4'd15, v); check("R3 clear both", v, 8'h00);

      // R5 R6 R9 R10 full rollover in 24-hour mode
      load(50, 59, 23, 6, 31, 12, 99, 0);
      for (int i = 0; i < 15; i++) begin
         tick(); model_step(); check_all("R10 R6 R5 R9 rollover");
      end
      load(59, 59, 23, 6, 31, 12, 99, 1);
      tick(); model_step(); check_all("R10 century back");

      // R8 month lengths, leap and common year
      for (int yi = 0; yi < 3; yi++) begin
         for (int mi = 1; mi <= 12; mi++) begin
            int yr;
            yr = (yi == 0) ? 23 : (yi == 1) ? 24 : 96;
            load(59, 59, 23, mi % 7, mlen(mi, yr), mi, yr, 0);
            tick(); model_step(); check_all("R8 month end");
         end
      end
      load(59, 59, 23, 1, 28, 2, 24, 0);
      tick(); model_step(); check_all("R8 leap 28th");

      // R7 12-hour encoding over every hour
      set_mode(0);
      for (int hr = 0; hr < 24; hr++) begin
         load(59, 59, hr, 3, 15, 6, 10, 0);
         tick(); model_step(); check_all("R7 hour12");
      end
      rd(4'd14, v); check("R7 mode12", v, 8'h00);

      // R11 write beats tick
      set_mode(1);
      load(10, 5, 8, 1, 2, 3, 4, 0);
      @(negedge clk);
      tick_i = 1'b1; wr_en_i = 1'b1; addr_i = 4'd1; wdata_i = 8'h20;
      @(negedge clk);
      tick_i = 1'b0; wr_en_i = 1'b0;
      m = 20;
      check_all("R11 write wins");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule